// File: doc/BRIEF.md
# Ordered I/O Access Monitor

This block sits beside a processor core and compares two views of its memory traffic: the accesses the core reports as retired, and the transactions that actually appear on its data bus. Only traffic whose address falls inside a configurable I/O window is considered. Everything else is dropped on both sides, so cached or reordered ordinary memory traffic never disturbs the comparison.

Each I/O bus transaction is queued as it is observed. Each retired I/O access takes the oldest queued transaction and is compared against it for address, kind (read or write), fault response and byte lanes. A read may be served by a wider bus read, but a write must drive exactly the bytes the core retired. Any discrepancy sets a sticky error flag of its own class, which stays set until reset, so a test harness or formal wrapper can simply watch six outputs.

The comparison works at the level of addresses, byte masks and fault responses; payload data is not compared.

Top module: `io_order_monitor`

## Requirements
- R1: An address is I/O exactly when `(addr & IO_MASK) == IO_BASE` (defaults: mask 0xF000_0000, base 0x4000_0000); a retirement or bus transaction counts only when its valid input is high, its address is I/O and at least one bit of its read or write byte mask is set.
- R2: A counted retirement that finds no queued bus transaction sets `err_missing` after the next clock edge; a bus transaction must be presented in an earlier cycle than the retirement it serves.
- R3: For a matched, non-faulting read, every retired read byte must be present in the bus read mask; extra bus read bytes are allowed, a retired read byte absent from the bus mask sets `err_split`.
- R4: For a matched, non-faulting write, a bus write byte outside the retired write mask sets `err_widened`, and a retired write byte absent from the bus write mask sets `err_split`.
- R5: An access is a write when its write mask is nonzero, otherwise a read; if the queued transaction's word address (address with the byte-lane bits dropped) or kind differs from the retirement, `err_order` is set and the mask checks of R3 and R4 are skipped.
- R6: If the retired fault flag differs from the fault response of the matched bus transaction, `err_fault` is set; when either side faulted, the mask checks of R3 and R4 are skipped.
- R7: A matched bus transaction carrying both read and write bytes in one cycle sets `err_merged`.
- R8: Non-I/O retirements neither consume a queued transaction nor raise an error, and non-I/O bus transactions are never queued.
- R9: Up to `DEPTH` (default 8) bus transactions may wait; a further counted bus transaction arriving with the queue full and no retirement in that cycle is dropped and sets `err_order`.
- R10: Every error flag is 0 after reset and, once set, stays set until reset.
- R11: Retirements are matched against bus transactions strictly oldest first, one transaction per retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | A memory access retires this cycle |
| ret_addr | input | AW | Retired access address |
| ret_rmask | input | BW | Retired read byte lanes |
| ret_wmask | input | BW | Retired write byte lanes |
| ret_fault | input | 1 | Retired access took an access fault |
| bus_valid | input | 1 | A bus transaction completes this cycle |
| bus_addr | input | AW | Bus transaction address |
| bus_rmask | input | BW | Bus read byte lanes |
| bus_wmask | input | BW | Bus write byte lanes |
| bus_fault | input | 1 | Bus returned a fault response |
| err_missing | output | 1 | Sticky: retirement without a queued transaction |
| err_split | output | 1 | Sticky: retired bytes not covered by one bus cycle |
| err_widened | output | 1 | Sticky: bus write touched extra bytes |
| err_merged | output | 1 | Sticky: one bus cycle carried read and write bytes |
| err_fault | output | 1 | Sticky: fault flag disagreement |
| err_order | output | 1 | Sticky: address/kind mismatch or queue overrun |

## Verification
The assertions presume that each bus transaction is presented in a single cycle with its valid held for exactly that cycle, and that retirements report at most one access per cycle; they also presume the queue never needs to hold more than its depth unless the overrun case is being exercised. The stimulus holds every input steady between falling edges, raises at most one bus and one retirement event per cycle, always presents a bus transaction at least one cycle before the retirement it should match, and resets the monitor between scenarios so each sticky flag is observed in isolation.

// File: rtl/io_mon_pkg.sv
package io_mon_pkg;

    // One bit per error class; bit order matches the sticky outputs.
    typedef struct packed {
        logic missing;
        logic split;
        logic widened;
        logic merged;
        logic fault;
        logic order;
    } io_err_t;

    localparam io_err_t IO_ERR_NONE = '{default: 1'b0};

endpackage

// File: rtl/io_mon_region.sv
module io_mon_region #(
    parameter int          AW      = 32,
    parameter logic [AW-1:0] IO_BASE = 32'h4000_0000,
    parameter logic [AW-1:0] IO_MASK = 32'hF000_0000
) (
    input  logic [AW-1:0] addr,
    output logic          is_io
);

    // Window decode: masked address bits must equal the base pattern.
    always_comb begin
        is_io = ((addr & IO_MASK) == (IO_BASE & IO_MASK));
    end

endmodule

// File: rtl/io_mon_fifo.sv
module io_mon_fifo #(
    parameter int W     = 35,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         dropped
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNT_FULL) || do_pop);
        dropped = push && !do_push;

        if (do_push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_FULL);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL); // R9

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (st_q.cnt == $past(st_q.cnt))); // R9

    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R11

endmodule

// File: rtl/io_mon_match.sv
module io_mon_match
    import io_mon_pkg::*;
#(
    parameter int WAW = 30,
    parameter int BW  = 4
) (
    input  logic [WAW-1:0] ret_word,
    input  logic [BW-1:0]  ret_rmask,
    input  logic [BW-1:0]  ret_wmask,
    input  logic           ret_fault,
    input  logic [WAW-1:0] hd_word,
    input  logic [BW-1:0]  hd_rmask,
    input  logic [BW-1:0]  hd_wmask,
    input  logic           hd_fault,
    output io_err_t        cmp_err
);

    logic ret_is_wr, hd_is_wr, same_slot, clean, rd_uncovered, wr_uncovered, wr_extra;

    always_comb begin
        ret_is_wr    = |ret_wmask;
        hd_is_wr     = |hd_wmask;
        same_slot    = (ret_word == hd_word) && (ret_is_wr == hd_is_wr);
        clean        = same_slot && !ret_fault && !hd_fault;
        rd_uncovered = |(ret_rmask & ~hd_rmask);
        wr_uncovered = |(ret_wmask & ~hd_wmask);
        wr_extra     = |(hd_wmask & ~ret_wmask);

        cmp_err         = IO_ERR_NONE;
        cmp_err.order   = !same_slot;
        cmp_err.fault   = (ret_fault != hd_fault);
        cmp_err.merged  = (|hd_rmask) && (|hd_wmask);
        cmp_err.split   = clean && (rd_uncovered || wr_uncovered);
        cmp_err.widened = clean && wr_extra;
    end

endmodule

// File: rtl/io_order_monitor.sv
module io_order_monitor
    import io_mon_pkg::*;
#(
    parameter int            AW      = 32,
    parameter int            BW      = 4,
    parameter int            DEPTH   = 8,
    parameter logic [AW-1:0] IO_BASE = 32'h4000_0000,
    parameter logic [AW-1:0] IO_MASK = 32'hF000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_addr,
    input  logic [BW-1:0] ret_rmask,
    input  logic [BW-1:0] ret_wmask,
    input  logic          ret_fault,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_rmask,
    input  logic [BW-1:0] bus_wmask,
    input  logic          bus_fault,
    output logic          err_missing,
    output logic          err_split,
    output logic          err_widened,
    output logic          err_merged,
    output logic          err_fault,
    output logic          err_order
);

    localparam int OFFS = (BW > 1) ? $clog2(BW) : 0;
    localparam int WAW  = AW - OFFS;
    localparam int EW   = WAW + 2 * BW + 1;

    typedef struct packed {
        logic [WAW-1:0] word;
        logic [BW-1:0]  rmask;
        logic [BW-1:0]  wmask;
        logic           fault;
    } slot_t;

    typedef struct packed {
        io_err_t err;
    } mon_st_t;

    mon_st_t st_d, st_q;

    logic    ret_in_win, bus_in_win;
    logic    ret_io, bus_io;
    logic    q_push, q_pop, q_empty, q_full, q_dropped;
    slot_t   bus_slot, head_slot;
    logic [EW-1:0] head_raw;
    io_err_t cmp_err;

    io_mon_region #(.AW(AW), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) u_ret_win (
        .addr  (ret_addr),
        .is_io (ret_in_win)
    );

    io_mon_region #(.AW(AW), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) u_bus_win (
        .addr  (bus_addr),
        .is_io (bus_in_win)
    );

    always_comb begin
        ret_io = ret_valid && ret_in_win && ((|ret_rmask) || (|ret_wmask));
        bus_io = bus_valid && bus_in_win && ((|bus_rmask) || (|bus_wmask));
        q_push = bus_io;
        q_pop  = ret_io;

        bus_slot.word  = bus_addr[AW-1:OFFS];
        bus_slot.rmask = bus_rmask;
        bus_slot.wmask = bus_wmask;
        bus_slot.fault = bus_fault;
        head_slot      = slot_t'(head_raw);
    end

    io_mon_fifo #(.W(EW), .DEPTH(DEPTH)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (q_push),
        .din     (EW'(bus_slot)),
        .pop     (q_pop),
        .head    (head_raw),
        .empty   (q_empty),
        .full    (q_full),
        .dropped (q_dropped)
    );

    io_mon_match #(.WAW(WAW), .BW(BW)) u_cmp (
        .ret_word  (ret_addr[AW-1:OFFS]),
        .ret_rmask (ret_rmask),
        .ret_wmask (ret_wmask),
        .ret_fault (ret_fault),
        .hd_word   (head_slot.word),
        .hd_rmask  (head_slot.rmask),
        .hd_wmask  (head_slot.wmask),
        .hd_fault  (head_slot.fault),
        .cmp_err   (cmp_err)
    );

    always_comb begin
        st_d = st_q;
        if (ret_io && q_empty) begin
            st_d.err.missing = 1'b1;
        end
        if (ret_io && !q_empty) begin
            st_d.err = st_q.err | cmp_err;
        end
        if (q_dropped) begin
            st_d.err.order = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_missing = st_q.err.missing;
    assign err_split   = st_q.err.split;
    assign err_widened = st_q.err.widened;
    assign err_merged  = st_q.err.merged;
    assign err_fault   = st_q.err.fault;
    assign err_order   = st_q.err.order;

    AST_MISSING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_io && q_empty) |=> err_missing); // R2

    AST_OVERRUN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_io && q_full && !ret_io) |=> err_order); // R9

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_io && !bus_io) |=> $stable(st_q.err)); // R8

    AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.err & $past(st_q.err)) == $past(st_q.err))); // R10

    AST_NONIO_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_io && !bus_io) |=> $stable(q_empty)); // R8

endmodule

// File: tb/io_order_monitor_test.sv
`timescale 1ns/1ps
module io_order_monitor_test;

    localparam int AW = 32;
    localparam int BW = 4;
    localparam time PERIOD = 20ns;

    localparam logic [5:0] NONE = 6'b000000;
    localparam logic [5:0] EM   = 6'b100000;
    localparam logic [5:0] ES   = 6'b010000;
    localparam logic [5:0] EW   = 6'b001000;
    localparam logic [5:0] EG   = 6'b000100;
    localparam logic [5:0] EF   = 6'b000010;
    localparam logic [5:0] EO   = 6'b000001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ret_valid = 1'b0;
    logic [AW-1:0] ret_addr = '0;
    logic [BW-1:0] ret_rmask = '0;
    logic [BW-1:0] ret_wmask = '0;
    logic          ret_fault = 1'b0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [BW-1:0] bus_rmask = '0;
    logic [BW-1:0] bus_wmask = '0;
    logic          bus_fault = 1'b0;
    logic          err_missing, err_split, err_widened, err_merged, err_fault, err_order;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;

    typedef struct {
        int         due;
        logic [5:0] exp;
        string      tag;
    } item_t;
    item_t sq[$];

    io_order_monitor #(.AW(AW), .BW(BW), .DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_rmask(ret_rmask),
        .ret_wmask(ret_wmask), .ret_fault(ret_fault),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_rmask(bus_rmask),
        .bus_wmask(bus_wmask), .bus_fault(bus_fault),
        .err_missing(err_missing), .err_split(err_split), .err_widened(err_widened),
        .err_merged(err_merged), .err_fault(err_fault), .err_order(err_order)
    );

    always #(PERIOD/2) clk = ~clk;
    always_ff @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare outputs with every expectation that has come due.
    always @(negedge clk) begin
        logic [5:0] got;
        got = {err_missing, err_split, err_widened, err_merged, err_fault, err_order};
        while (sq.size() > 0 && sq[0].due <= cyc) begin
            item_t it;
            it = sq.pop_front();
            n_checks++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: flags got %b expected %b", it.tag, got, it.exp);
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue the flags expected after it.
    task automatic drive(input logic rv, input logic [AW-1:0] ra, input logic [BW-1:0] rr,
                         input logic [BW-1:0] rw, input logic rf,
                         input logic bv, input logic [AW-1:0] ba, input logic [BW-1:0] br,
                         input logic [BW-1:0] bw, input logic bf,
                         input logic [5:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        ret_valid = rv; ret_addr = ra; ret_rmask = rr; ret_wmask = rw; ret_fault = rf;
        bus_valid = bv; bus_addr = ba; bus_rmask = br; bus_wmask = bw; bus_fault = bf;
        it.due = cyc + 1; it.exp = exp; it.tag = tag;
        sq.push_back(it);
    endtask

    task automatic idle(input logic [5:0] exp, input string tag);
        drive(0, '0, '0, '0, 0, 0, '0, '0, '0, 0, exp, tag);
    endtask

    task automatic bus(input logic [AW-1:0] a, input logic [BW-1:0] r, input logic [BW-1:0] w,
                       input logic f, input logic [5:0] exp, input string tag);
        drive(0, '0, '0, '0, 0, 1, a, r, w, f, exp, tag);
    endtask

    task automatic ret(input logic [AW-1:0] a, input logic [BW-1:0] r, input logic [BW-1:0] w,
                       input logic f, input logic [5:0] exp, input string tag);
        drive(1, a, r, w, f, 0, '0, '0, '0, 0, exp, tag);
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        ret_valid = 0; bus_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(NONE, "R10 reset clears flags");
    endtask

    localparam logic [AW-1:0] A0 = 32'h4000_0010;
    localparam logic [AW-1:0] A1 = 32'h4000_0024;
    localparam logic [AW-1:0] NIO = 32'h5000_0010;

    initial begin
        reset_dut();

        // R3/R11 exact read then over-fetching read
        bus(A0, 4'b0011, 4'b0000, 0, NONE, "R3 bus read queued");
        ret(A0, 4'b0011, 4'b0000, 0, NONE, "R3 exact read match");
        bus(A0 + 2, 4'b1111, 4'b0000, 0, NONE, "R3 wide bus read queued");
        ret(A0, 4'b0100, 4'b0000, 0, NONE, "R3 over-fetch allowed");
        idle(NONE, "R11 queue drained quietly");

        // R3 uncovered read byte
        reset_dut();
        bus(A0, 4'b0001, 4'b0000, 0, NONE, "R3 narrow bus read");
        ret(A0, 4'b0011, 4'b0000, 0, ES, "R3 read not covered");
        idle(ES, "R10 split stays set");

        // R4 write exact, widened, uncovered
        reset_dut();
        bus(A1, 4'b0000, 4'b1100, 0, NONE, "R4 bus write queued");
        ret(A1, 4'b0000, 4'b1100, 0, NONE, "R4 exact write");
        bus(A1, 4'b0000, 4'b1111, 0, NONE, "R4 wide bus write");
        ret(A1, 4'b0000, 4'b0011, 0, EW, "R4 widened write");
        reset_dut();
        bus(A1, 4'b0000, 4'b0001, 0, NONE, "R4 short bus write");
        ret(A1, 4'b0000, 4'b0011, 0, ES, "R4 write split");

        // R2 missing, including same-cycle bus and retirement
        reset_dut();
        ret(A0, 4'b1111, 4'b0000, 0, EM, "R2 retire with empty queue");
        reset_dut();
        drive(1, A0, 4'b0001, 4'b0000, 0, 1, A0, 4'b0001, 4'b0000, 0, EM,
              "R2 same-cycle bus does not serve");

        // R5/R11 order
        reset_dut();
        bus(A0, 4'b0001, 4'b0000, 0, NONE, "R11 first queued");
        bus(A1, 4'b0001, 4'b0000, 0, NONE, "R11 second queued");
        ret(A0, 4'b0001, 4'b0000, 0, NONE, "R11 oldest matches");
        ret(A1, 4'b0001, 4'b0000, 0, NONE, "R11 next matches");
        reset_dut();
        bus(A0, 4'b0001, 4'b0000, 0, NONE, "R5 first queued");
        bus(A1, 4'b0001, 4'b0000, 0, NONE, "R5 second queued");
        ret(A1, 4'b0001, 4'b0000, 0, EO, "R5 swapped retirement");

        // R5 kind mismatch
        reset_dut();
        bus(A0, 4'b0000, 4'b0011, 0, NONE, "R5 bus write queued");
        ret(A0, 4'b0011, 4'b0000, 0, EO, "R5 retired read vs bus write");

        // R6 faults
        reset_dut();
        bus(A0, 4'b0001, 4'b0000, 1, NONE, "R6 faulting bus read");
        ret(A0, 4'b1111, 4'b0000, 1, NONE, "R6 fault matches, masks skipped");
        bus(A1, 4'b0000, 4'b0011, 0, NONE, "R6 clean bus write");
        ret(A1, 4'b0000, 4'b0011, 1, EF, "R6 fault disagreement");

        // R7 merged
        reset_dut();
        bus(A0, 4'b1100, 4'b0011, 0, NONE, "R7 mixed bus cycle");
        ret(A0, 4'b0000, 4'b0011, 0, EG, "R7 merged detected");

        // R1/R8 non-I/O traffic
        reset_dut();
        ret(NIO, 4'b0001, 4'b0000, 0, NONE, "R1 0x5000_0010 is not I/O");
        bus(NIO, 4'b0000, 4'b1111, 0, NONE, "R8 non-I/O bus ignored");
        bus(A0, 4'b0001, 4'b0000, 0, NONE, "R8 I/O bus queued");
        ret(NIO, 4'b0000, 4'b0001, 0, NONE, "R8 non-I/O retire does not pop");
        ret(A0, 4'b0001, 4'b0000, 0, NONE, "R8 I/O matched after non-I/O");
        ret(32'h4FFF_FFFC, 4'b0001, 4'b0000, 0, EM, "R1 0x4FFF_FFFC is I/O");
        reset_dut();
        ret(A0, 4'b0000, 4'b0000, 0, NONE, "R1 empty masks not counted");

        // R9 overrun
        reset_dut();
        for (int i = 0; i < 8; i++) begin
            bus(32'h4000_0000 + 32'(4 * i), 4'b0001, 4'b0000, 0, NONE, "R9 fill queue");
        end
        bus(32'h4000_0100, 4'b0001, 4'b0000, 0, EO, "R9 overrun flagged");
        ret(32'h4000_0000, 4'b0001, 4'b0000, 0, EO, "R9 oldest still first");

        idle(EO, "R10 order stays set");
        idle(EO, "R10 order stays set again");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule